// File: doc/BRIEF.md
# Bidirectional Mailbox Register Pair

This block carries short control words between two ports that run on unrelated clocks, alongside a data queue but outside it. Port A posts a word into the A-to-B mailbox and port B collects it; port B posts into the B-to-A mailbox and port A collects it. Each mailbox has a "free" flag: HIGH means no unread mail, LOW means a word is waiting. The writer's access clears the flag in the writer's clock domain. The reader's access sets it again in the reader's clock domain. Toggle handshakes with two-flop synchronizers carry these changes between the domains, so each port sees both mailbox flags timed to its own clock.

Each port decodes its own strobes: an active-low select, a write/read direction, an enable, and a mailbox select. The block also drives the port's read bus. When the port is reading, the bus carries the incoming mailbox word if mailbox select is HIGH, and otherwise the queue's output word, which arrives on an input from outside. The bus tri-state is shown as an output-enable signal plus a data bus. While the output enable is LOW, the bus is driven to zero.

Top module: `mailbox_pair`

## Requirements
- R1: After reset, all four free flags (`mbx_ab_free_a`, `mbx_ab_free_b`, `mbx_ba_free_a`, `mbx_ba_free_b`) are HIGH and both mailbox words read as zero.
- R2: A mailbox write occurs on a port's clock edge when select is LOW, write/read is HIGH (1 = write), enable is HIGH, mailbox select is HIGH, and the writer-side free flag is HIGH. It stores the port's input word, and after that edge the writer-side free flag is LOW.
- R3: A mailbox write attempted while the writer-side free flag is LOW leaves the stored word unchanged.
- R4: After an accepted write, the reader-side free flag of that mailbox goes LOW within four reader clock cycles. While it is LOW, the writer-side flag is also LOW.
- R5: A mailbox read occurs when select is LOW, write/read is LOW, enable is HIGH, and mailbox select is HIGH. If it happens while the reader-side flag is LOW, the reader-side flag is HIGH after that edge. The writer-side flag returns HIGH within four writer clock cycles.
- R6: Reading a mailbox does not change its stored word. Only an accepted write does.
- R7: While the output enable is HIGH, the port's data bus shows the incoming mailbox word if mailbox select is HIGH, and otherwise the port's queue output word.
- R8: The output enable is HIGH only when select is LOW and write/read is LOW. When it is LOW, the data bus is all zero.
- R9: Accesses with mailbox select LOW, or with enable LOW, leave all mailbox flags and words unchanged.
- R10: The two mailboxes are independent: a transfer in one direction leaves the other mailbox's flags and word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| a_cs_n | input | 1 | Port A select, active LOW |
| a_wr | input | 1 | Port A direction, 1 = write, 0 = read |
| a_en | input | 1 | Port A transfer enable |
| a_mb | input | 1 | Port A mailbox select |
| a_din | input | W | Port A write data |
| a_fifo_q | input | W | Queue output word for port A reads |
| a_oe | output | 1 | Port A bus drive enable |
| a_dout | output | W | Port A read bus |
| b_cs_n | input | 1 | Port B select, active LOW |
| b_wr | input | 1 | Port B direction, 1 = write, 0 = read |
| b_en | input | 1 | Port B transfer enable |
| b_mb | input | 1 | Port B mailbox select |
| b_din | input | W | Port B write data |
| b_fifo_q | input | W | Queue output word for port B reads |
| b_oe | output | 1 | Port B bus drive enable |
| b_dout | output | W | Port B read bus |
| mbx_ab_free_a | output | 1 | A-to-B mailbox free, port A clock |
| mbx_ab_free_b | output | 1 | A-to-B mailbox free, port B clock |
| mbx_ba_free_a | output | 1 | B-to-A mailbox free, port A clock |
| mbx_ba_free_b | output | 1 | B-to-A mailbox free, port B clock |

## Verification
The assertions check four things on every cycle. An accepted write drops the writer's flag on the next edge. A locked mailbox word never changes. A read of pending mail raises the reader's flag. A pending flag on the reader side always matches a pending flag on the writer side. Other behaviours can only be shown by the bench's scenarios: the crossing latency in each direction, the data seen on the read bus, that reads keep the stored word, and that non-mailbox traffic and the opposite direction leave a mailbox alone. The bench runs these under random data and random strobe combinations with two unrelated clock periods.

// File: rtl/mailbox_pair.sv
`timescale 1ns/1ps
module mailbox_pair #(
  parameter int W = 36
) (
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         rst_n,
  input  logic         a_cs_n,
  input  logic         a_wr,
  input  logic         a_en,
  input  logic         a_mb,
  input  logic [W-1:0] a_din,
  input  logic [W-1:0] a_fifo_q,
  output logic         a_oe,
  output logic [W-1:0] a_dout,
  input  logic         b_cs_n,
  input  logic         b_wr,
  input  logic         b_en,
  input  logic         b_mb,
  input  logic [W-1:0] b_din,
  input  logic [W-1:0] b_fifo_q,
  output logic         b_oe,
  output logic [W-1:0] b_dout,
  output logic         mbx_ab_free_a,
  output logic         mbx_ab_free_b,
  output logic         mbx_ba_free_a,
  output logic         mbx_ba_free_b
);

  logic [W-1:0] ab_word, ba_word;
  logic         ab_wtog, ab_rtog, ba_wtog, ba_rtog;
  logic [1:0]   ab_rsync_a, ab_wsync_b, ba_wsync_a, ba_rsync_b;

  wire a_mwr = !a_cs_n &&  a_wr && a_en && a_mb;
  wire a_mrd = !a_cs_n && !a_wr && a_en && a_mb;
  wire b_mwr = !b_cs_n &&  b_wr && b_en && b_mb;
  wire b_mrd = !b_cs_n && !b_wr && b_en && b_mb;

  assign mbx_ab_free_a = (ab_wtog == ab_rsync_a[1]);
  assign mbx_ab_free_b = (ab_wsync_b[1] == ab_rtog);
  assign mbx_ba_free_b = (ba_wtog == ba_rsync_b[1]);
  assign mbx_ba_free_a = (ba_wsync_a[1] == ba_rtog);

  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) begin
      ab_word    <= '0;
      ab_wtog    <= 1'b0;
      ba_rtog    <= 1'b0;
      ab_rsync_a <= '0;
      ba_wsync_a <= '0;
    end else begin
      if (a_mwr && mbx_ab_free_a) begin
        ab_word <= a_din;
        ab_wtog <= ~ab_wtog;
      end
      if (a_mrd && !mbx_ba_free_a)
        ba_rtog <= ~ba_rtog;
      ab_rsync_a <= {ab_rsync_a[0], ab_rtog};
      ba_wsync_a <= {ba_wsync_a[0], ba_wtog};
    end
  end

  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      ba_word    <= '0;
      ba_wtog    <= 1'b0;
      ab_rtog    <= 1'b0;
      ba_rsync_b <= '0;
      ab_wsync_b <= '0;
    end else begin
      if (b_mwr && mbx_ba_free_b) begin
        ba_word <= b_din;
        ba_wtog <= ~ba_wtog;
      end
      if (b_mrd && !mbx_ab_free_b)
        ab_rtog <= ~ab_rtog;
      ba_rsync_b <= {ba_rsync_b[0], ba_rtog};
      ab_wsync_b <= {ab_wsync_b[0], ab_wtog};
    end
  end

  assign a_oe   = !a_cs_n && !a_wr;
  assign b_oe   = !b_cs_n && !b_wr;
  assign a_dout = a_oe ? (a_mb ? ba_word : a_fifo_q) : '0;
  assign b_dout = b_oe ? (b_mb ? ab_word : b_fifo_q) : '0;

  assert_ab_write_takes_R2: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_mwr && mbx_ab_free_a) |=> !mbx_ab_free_a);
  assert_ba_write_takes_R2: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_mwr && mbx_ba_free_b) |=> !mbx_ba_free_b);

  assert_ab_locked_R3: assert property (@(posedge clk_a) disable iff (!rst_n)
    !mbx_ab_free_a |=> $stable(ab_word));
  assert_ba_locked_R3: assert property (@(posedge clk_b) disable iff (!rst_n)
    !mbx_ba_free_b |=> $stable(ba_word));

  assert_ab_read_frees_R5: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_mrd && !mbx_ab_free_b) |=> mbx_ab_free_b);
  assert_ba_read_frees_R5: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_mrd && !mbx_ba_free_a) |=> mbx_ba_free_a);

  assert_ab_pending_pair_R4: assert property (@(posedge clk_b) disable iff (!rst_n)
    !mbx_ab_free_b |-> !mbx_ab_free_a);
  assert_ba_pending_pair_R4: assert property (@(posedge clk_a) disable iff (!rst_n)
    !mbx_ba_free_a |-> !mbx_ba_free_b);

endmodule

// File: tb/sim_mailbox_pair.sv
`timescale 1ns/1ps
module sim_mailbox_pair;
  localparam int W = 36;

  logic clk_a = 0, clk_b = 0, rst_n = 0;
  logic a_cs_n = 1, a_wr = 0, a_en = 0, a_mb = 0;
  logic b_cs_n = 1, b_wr = 0, b_en = 0, b_mb = 0;
  logic [W-1:0] a_din = '0, a_fifo_q = '0, b_din = '0, b_fifo_q = '0;
  logic a_oe, b_oe;
  logic [W-1:0] a_dout, b_dout;
  logic mbx_ab_free_a, mbx_ab_free_b, mbx_ba_free_a, mbx_ba_free_b;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [W-1:0] last_ab = '0, last_ba = '0;

  always #5 clk_a = ~clk_a;
  always #6.5 clk_b = ~clk_b;

  mailbox_pair #(.W(W)) u0 (.*);

  function automatic logic [W-1:0] rnd_word();
    return {$urandom(), $urandom()} & {W{1'b1}};
  endfunction

  function automatic logic exp_oe(input logic cs_n, input logic wr);
    return !cs_n && !wr;
  endfunction

  function automatic logic [W-1:0] exp_bus(input logic cs_n, input logic wr, input logic mb,
                                           input logic [W-1:0] mail, input logic [W-1:0] fq);
    return exp_oe(cs_n, wr) ? (mb ? mail : fq) : '0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_a(input logic cs_n, input logic wr, input logic en, input logic mb, input logic [W-1:0] d);
    a_cs_n = cs_n; a_wr = wr; a_en = en; a_mb = mb; a_din = d;
  endtask

  task automatic set_b(input logic cs_n, input logic wr, input logic en, input logic mb, input logic [W-1:0] d);
    b_cs_n = cs_n; b_wr = wr; b_en = en; b_mb = mb; b_din = d;
  endtask

  task automatic xfer_ab(input logic [W-1:0] d);
    bit ok;
    @(negedge clk_a); set_a(0, 1, 1, 1, d);
    @(negedge clk_a); set_a(1, 0, 0, 0, '0);
    chk(!mbx_ab_free_a, "R2 writer flag low", W'(mbx_ab_free_a), '0);
    chk(mbx_ba_free_a && mbx_ba_free_b, "R10 other mailbox free", W'({mbx_ba_free_a, mbx_ba_free_b}), W'(3));
    ok = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_b);
      if (!mbx_ab_free_b) begin ok = 1; break; end
    end
    chk(ok, "R4 reader flag low", W'(mbx_ab_free_b), '0);
    @(negedge clk_a); set_a(0, 1, 1, 1, ~d);
    @(negedge clk_a); set_a(1, 0, 0, 0, '0);
    @(negedge clk_b); set_b(0, 0, 0, 1, '0); #1;
    chk(b_oe && b_dout == d, "R3/R7 locked word on bus", b_dout, d);
    set_b(0, 0, 1, 1, '0);
    @(negedge clk_b); set_b(0, 0, 0, 1, '0); #1;
    chk(mbx_ab_free_b, "R5 reader flag high", W'(mbx_ab_free_b), W'(1));
    chk(b_dout == d, "R6 word kept after read", b_dout, d);
    set_b(1, 0, 0, 0, '0);
    ok = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_a);
      if (mbx_ab_free_a) begin ok = 1; break; end
    end
    chk(ok, "R5 writer flag high", W'(mbx_ab_free_a), W'(1));
    last_ab = d;
  endtask

  task automatic xfer_ba(input logic [W-1:0] d);
    bit ok;
    @(negedge clk_b); set_b(0, 1, 1, 1, d);
    @(negedge clk_b); set_b(1, 0, 0, 0, '0);
    chk(!mbx_ba_free_b, "R2 writer flag low", W'(mbx_ba_free_b), '0);
    chk(mbx_ab_free_a && mbx_ab_free_b, "R10 other mailbox free", W'({mbx_ab_free_a, mbx_ab_free_b}), W'(3));
    ok = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_a);
      if (!mbx_ba_free_a) begin ok = 1; break; end
    end
    chk(ok, "R4 reader flag low", W'(mbx_ba_free_a), '0);
    @(negedge clk_b); set_b(0, 1, 1, 1, ~d);
    @(negedge clk_b); set_b(1, 0, 0, 0, '0);
    @(negedge clk_a); set_a(0, 0, 0, 1, '0); #1;
    chk(a_oe && a_dout == d, "R3/R7 locked word on bus", a_dout, d);
    set_a(0, 0, 1, 1, '0);
    @(negedge clk_a); set_a(0, 0, 0, 1, '0); #1;
    chk(mbx_ba_free_a, "R5 reader flag high", W'(mbx_ba_free_a), W'(1));
    chk(a_dout == d, "R6 word kept after read", a_dout, d);
    set_a(1, 0, 0, 0, '0);
    ok = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_b);
      if (mbx_ba_free_b) begin ok = 1; break; end
    end
    chk(ok, "R5 writer flag high", W'(mbx_ba_free_b), W'(1));
    last_ba = d;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #33 rst_n = 1;
    @(negedge clk_a);
    chk(mbx_ab_free_a && mbx_ab_free_b && mbx_ba_free_a && mbx_ba_free_b, "R1 flags after reset",
        W'({mbx_ab_free_a, mbx_ab_free_b, mbx_ba_free_a, mbx_ba_free_b}), W'(15));
    set_a(0, 0, 0, 1, '0); set_b(0, 0, 0, 1, '0); #1;
    chk(a_dout == '0 && b_dout == '0, "R1 words after reset", a_dout | b_dout, '0);
    set_a(1, 0, 0, 0, '0); set_b(1, 0, 0, 0, '0);

    xfer_ab(36'hA_5A5A_5A5A);
    xfer_ba(36'h5_A5A5_A5A5);
    xfer_ab('1);
    xfer_ba('0);

    for (int i = 0; i < 4; i++) begin
      logic [W-1:0] junk;
      junk = rnd_word();
      @(negedge clk_a); set_a(0, 1, 0, 1, junk);
      @(negedge clk_a); set_a(0, 1, 1, 0, junk);
      @(negedge clk_a); set_a(0, 0, 1, 0, junk);
      @(negedge clk_a); set_a(1, 0, 0, 0, '0);
      @(negedge clk_b); set_b(0, 1, 0, 1, junk);
      @(negedge clk_b); set_b(0, 1, 1, 0, junk);
      @(negedge clk_b); set_b(0, 0, 1, 0, junk);
      @(negedge clk_b); set_b(0, 0, 0, 1, '0); #1;
      chk(b_dout == last_ab, "R9 A-to-B word untouched", b_dout, last_ab);
      set_b(1, 0, 0, 0, '0);
      @(negedge clk_a); set_a(0, 0, 0, 1, '0); #1;
      chk(a_dout == last_ba, "R9 B-to-A word untouched", a_dout, last_ba);
      set_a(1, 0, 0, 0, '0);
      repeat (4) @(negedge clk_a);
      chk(mbx_ab_free_a && mbx_ab_free_b && mbx_ba_free_a && mbx_ba_free_b, "R9 flags untouched",
          W'({mbx_ab_free_a, mbx_ab_free_b, mbx_ba_free_a, mbx_ba_free_b}), W'(15));
    end

    for (int i = 0; i < 40; i++) begin
      logic cs, wr, mb;
      logic [W-1:0] fq;
      cs = 1'($urandom()); wr = 1'($urandom()); mb = 1'($urandom()); fq = rnd_word();
      @(negedge clk_a); set_a(cs, wr, 0, mb, rnd_word()); a_fifo_q = fq; #1;
      chk(a_oe == exp_oe(cs, wr), "R8 port A enable", W'(a_oe), W'(exp_oe(cs, wr)));
      chk(a_dout == exp_bus(cs, wr, mb, last_ba, fq), "R7/R8 port A bus", a_dout, exp_bus(cs, wr, mb, last_ba, fq));
      cs = 1'($urandom()); wr = 1'($urandom()); mb = 1'($urandom()); fq = rnd_word();
      @(negedge clk_b); set_b(cs, wr, 0, mb, rnd_word()); b_fifo_q = fq; #1;
      chk(b_oe == exp_oe(cs, wr), "R8 port B enable", W'(b_oe), W'(exp_oe(cs, wr)));
      chk(b_dout == exp_bus(cs, wr, mb, last_ab, fq), "R7/R8 port B bus", b_dout, exp_bus(cs, wr, mb, last_ab, fq));
    end
    set_a(1, 0, 0, 0, '0); set_b(1, 0, 0, 0, '0);

    for (int i = 0; i < 30; i++) begin
      if ($urandom() % 2) xfer_ab(rnd_word());
      else xfer_ba(rnd_word());
      repeat ($urandom() % 5) @(negedge clk_a);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule